// File: doc/BRIEF.md
# Single-Lane SPI Flash Transfer Sequencer

This block runs one hand-built SPI flash transaction at a time. The host presents a set of phase enables and phase values, then pulses a start strobe. The engine concatenates the enabled phases into one bit stream and shifts it out MSB-first on MOSI in SPI mode 0. The phases always run in the same order: an 8-bit command, an 8-bit second command, a 24-bit address, one to four option bytes, one to eight idle dummy clocks, and a data phase of 8, 16 or 32 bits. During the data phase MISO is captured and returned right-justified.

A done flag tells the host when the engine may be started again. A start request made while the flag is low is refused with a one-cycle error pulse. A start request that asks for both read and write on a multi-lane data phase is refused the same way. A keep-select input leaves chip select asserted after the transaction. This lets the next transaction continue the same flash command, for example a program command whose payload spans several transactions.

Top module: `spi_xfer_engine`

## Requirements
- R1: The enabled phases are sent MSB-first in this fixed order: command (8 bits), second command (8 bits), address (24 bits), option bytes, dummy, data. A phase whose enable is low sends no bits.
- R2: With `opt_en` high, `opt_len`+1 bytes of option data are sent. They come from the top of `opt_data` downward: `opt_data[31:24]` first, then `[23:16]`, and so on.
- R3: With `dummy_en` high, `dummy_cyc`+1 SCLK cycles (1 to 8) are sent with MOSI low.
- R4: `data_size` selects the data phase: 0 none, 1 is 8 bits, 2 is 16 bits, 3 is 32 bits. With `wr_en` high, the low bits of `wdata` are sent MSB-first. With `wr_en` low, MOSI stays low during the data phase.
- R5: With `rd_en` high, MISO is sampled on each rising SCLK edge of the data phase. The result lands right-justified and zero-extended in `rdata` when the transfer ends. With `rd_en` low, `rdata` keeps its previous value.
- R6: SCLK idles low and each half period lasts `DIV_HALF` system clocks. MOSI never changes while SCLK is high. From the accepting clock edge to the setting of `xfer_end`, a transfer of N bits takes 2·DIV_HALF·N+1 clock cycles.
- R7: An accepted start clears `xfer_end` and asserts `cs_n` low on the same edge. `xfer_end` sets one system clock after the final falling SCLK edge, and `cs_n` returns high at that point.
- R8: If `keep_cs` was high at start, `cs_n` stays low after the transfer ends and through the following transaction.
- R9: A start while `xfer_end` is low raises `start_err` for one cycle and does not disturb the running transfer.
- R10: A start with `lane_wide` high, both `rd_en` and `wr_en` high and a data phase enabled is refused with `start_err`. In that case no SCLK edge occurs, `cs_n` stays high and `xfer_end` stays high. With `lane_wide` high and only one direction enabled, the start is accepted.
- R11: After reset `cs_n` is high, SCLK and MOSI are low, `xfer_end` is high, `start_err` is low and `rdata` is zero.
- R12: A start with no phase enabled produces no SCLK edge and sets `xfer_end` one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request strobe |
| cmd_en | input | 1 | Command phase enable |
| cmd | input | 8 | Command byte |
| ocmd_en | input | 1 | Second command phase enable |
| ocmd | input | 8 | Second command byte |
| addr_en | input | 1 | Address phase enable |
| addr | input | 24 | Flash address |
| opt_en | input | 1 | Option byte phase enable |
| opt_len | input | 2 | Number of option bytes minus one |
| opt_data | input | 32 | Option bytes, highest byte sent first |
| dummy_en | input | 1 | Dummy phase enable |
| dummy_cyc | input | 3 | Dummy SCLK cycles minus one |
| data_size | input | 2 | Data phase size code (0 off, 1/2/3 = 8/16/32 bits) |
| wdata | input | 32 | Write data, right-justified |
| rd_en | input | 1 | Capture MISO in the data phase |
| wr_en | input | 1 | Drive write data in the data phase |
| lane_wide | input | 1 | Data phase requested on more than one lane |
| keep_cs | input | 1 | Hold chip select after the transfer |
| miso | input | 1 | Serial data from the flash |
| sclk | output | 1 | Serial clock, mode 0 |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| rdata | output | 32 | Captured read data, right-justified |
| xfer_end | output | 1 | Previous transfer finished; start allowed |
| start_err | output | 1 | One-cycle pulse for a refused start |

## Verification
All 64 combinations of the six phase enables are swept. Each combination uses different option lengths, dummy counts, data sizes and read/write settings, so a wrong phase order, a skipped phase that still sends bits, or an off-by-one length shows up as a stream mismatch or a wrong cycle count. Separate sweeps of dummy count and option length isolate the two variable-length middle phases. A MISO pattern that differs on every edge shows whether capture is aligned to the data phase. Transfers with keep-select held, starts issued mid-transfer, and multi-lane read-plus-write requests separate legal and refused starts from one another.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  parameter int CMD_W     = 8;
  parameter int ADDR_W    = 24;
  parameter int OPT_BYTES = 4;
  parameter int DUMMY_MAX = 8;
  parameter int DATA_MAX  = 32;

  localparam int OPT_W    = 8 * OPT_BYTES;
  localparam int OLEN_W   = $clog2(OPT_BYTES);
  localparam int DCYC_W   = $clog2(DUMMY_MAX);
  localparam int STREAM_W = 2 * CMD_W + ADDR_W + OPT_W + DUMMY_MAX + DATA_MAX;
  localparam int CNT_W    = $clog2(STREAM_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } xfer_state_e;

  typedef struct packed {
    logic              cmd_en;
    logic [CMD_W-1:0]  cmd;
    logic              ocmd_en;
    logic [CMD_W-1:0]  ocmd;
    logic              addr_en;
    logic [ADDR_W-1:0] addr;
    logic              opt_en;
    logic [OLEN_W-1:0] opt_len;
    logic [OPT_W-1:0]  opt;
    logic              dummy_en;
    logic [DCYC_W-1:0] dummy_cyc;
    logic [1:0]        dsize;
    logic [DATA_MAX-1:0] wdata;
    logic              wr_en;
  } xfer_cfg_t;

  typedef struct packed {
    logic [STREAM_W-1:0] bits;
    logic [CNT_W-1:0]    len;
  } stream_t;

  // Size code to bit count: 0 none, 1 byte, 2 half word, 3 word.
  function automatic logic [CNT_W-1:0] data_len(input logic [1:0] code);
    case (code)
      2'd1:    return CNT_W'(8);
      2'd2:    return CNT_W'(16);
      2'd3:    return CNT_W'(DATA_MAX);
      default: return '0;
    endcase
  endfunction

  // Keep only the low bits of the write word that the data phase will send.
  function automatic logic [DATA_MAX-1:0] data_word(input logic [1:0] code,
                                                    input logic [DATA_MAX-1:0] w);
    case (code)
      2'd1:    return {{(DATA_MAX-8){1'b0}},  w[7:0]};
      2'd2:    return {{(DATA_MAX-16){1'b0}}, w[15:0]};
      2'd3:    return w;
      default: return '0;
    endcase
  endfunction

  // Concatenate enabled phases; the first bit to send ends up at index len-1.
  function automatic stream_t build_stream(input xfer_cfg_t c);
    stream_t s;
    int      n;
    s.bits = '0;
    s.len  = '0;
    if (c.cmd_en) begin
      s.bits = (s.bits << CMD_W) | STREAM_W'(c.cmd);
      s.len  = s.len + CNT_W'(CMD_W);
    end
    if (c.ocmd_en) begin
      s.bits = (s.bits << CMD_W) | STREAM_W'(c.ocmd);
      s.len  = s.len + CNT_W'(CMD_W);
    end
    if (c.addr_en) begin
      s.bits = (s.bits << ADDR_W) | STREAM_W'(c.addr);
      s.len  = s.len + CNT_W'(ADDR_W);
    end
    if (c.opt_en) begin
      n      = int'(c.opt_len) + 1;
      s.bits = (s.bits << (8 * n)) | STREAM_W'(c.opt >> (8 * (OPT_BYTES - n)));
      s.len  = s.len + CNT_W'(8 * n);
    end
    if (c.dummy_en) begin
      n      = int'(c.dummy_cyc) + 1;
      s.bits = s.bits << n;
      s.len  = s.len + CNT_W'(n);
    end
    if (c.dsize != 2'd0) begin
      n      = int'(data_len(c.dsize));
      s.bits = (s.bits << n) |
               (c.wr_en ? STREAM_W'(data_word(c.dsize, c.wdata)) : '0);
      s.len  = s.len + CNT_W'(n);
    end
    return s;
  endfunction

endpackage

// File: rtl/spi_xfer_clkgen.sv
module spi_xfer_clkgen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic ev_rise,
  output logic ev_fall
);
  localparam int HC_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [HC_W-1:0] hc;
  logic            tick;

  assign tick    = run && (hc == HC_W'(DIV_HALF - 1));
  assign ev_rise = tick && !sclk;
  assign ev_fall = tick && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc   <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      hc   <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      hc   <= '0;
      sclk <= !sclk;
    end else begin
      hc   <= hc + HC_W'(1);
    end
  end
endmodule

// File: rtl/spi_xfer_shifter.sv
module spi_xfer_shifter
  import spi_xfer_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  stream_t             load_stream,
  input  logic [CNT_W-1:0]    dlen,
  input  logic                capture_en,
  input  logic                ev_rise,
  input  logic                ev_fall,
  input  logic                miso,
  output logic                mosi,
  output logic [DATA_MAX-1:0] rbuf,
  output logic                last_bit,
  output logic                in_data
);
  logic [STREAM_W-1:0] sh;
  logic [CNT_W-1:0]    left;

  assign last_bit = (left == CNT_W'(1));
  assign in_data  = (left != '0) && (left <= dlen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
      mosi <= 1'b0;
      rbuf <= '0;
    end else if (load) begin
      sh   <= load_stream.bits;
      left <= load_stream.len;
      mosi <= (load_stream.len != '0) ?
              load_stream.bits[load_stream.len - CNT_W'(1)] : 1'b0;
      rbuf <= '0;
    end else begin
      if (ev_rise && in_data && capture_en)
        rbuf <= {rbuf[DATA_MAX-2:0], miso};
      if (ev_fall) begin
        if (left > CNT_W'(1)) begin
          left <= left - CNT_W'(1);
          mosi <= sh[left - CNT_W'(2)];
        end else begin
          left <= '0;
          mosi <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cmd_en,
  input  logic [CMD_W-1:0]    cmd,
  input  logic                ocmd_en,
  input  logic [CMD_W-1:0]    ocmd,
  input  logic                addr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                opt_en,
  input  logic [OLEN_W-1:0]   opt_len,
  input  logic [OPT_W-1:0]    opt_data,
  input  logic                dummy_en,
  input  logic [DCYC_W-1:0]   dummy_cyc,
  input  logic [1:0]          data_size,
  input  logic [DATA_MAX-1:0] wdata,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic                lane_wide,
  input  logic                keep_cs,
  input  logic                miso,
  output logic                sclk,
  output logic                cs_n,
  output logic                mosi,
  output logic [DATA_MAX-1:0] rdata,
  output logic                xfer_end,
  output logic                start_err
);
  xfer_state_e         state;
  xfer_cfg_t           cfg;
  stream_t             strm;
  logic                keep_q;
  logic                rd_q;
  logic [CNT_W-1:0]    dlen_q;
  logic [DATA_MAX-1:0] rbuf;
  logic                last_bit;
  logic                in_data;

  // Named internal events, observed by the bound checker.
  logic lane_conflict;
  logic accept;
  logic ev_rise;
  logic ev_fall;
  logic ev_last;
  logic ev_empty;
  logic in_fin;
  logic running;

  always_comb begin
    cfg.cmd_en    = cmd_en;
    cfg.cmd       = cmd;
    cfg.ocmd_en   = ocmd_en;
    cfg.ocmd      = ocmd;
    cfg.addr_en   = addr_en;
    cfg.addr      = addr;
    cfg.opt_en    = opt_en;
    cfg.opt_len   = opt_len;
    cfg.opt       = opt_data;
    cfg.dummy_en  = dummy_en;
    cfg.dummy_cyc = dummy_cyc;
    cfg.dsize     = data_size;
    cfg.wdata     = wdata;
    cfg.wr_en     = wr_en;
  end

  assign strm          = build_stream(cfg);
  assign lane_conflict = lane_wide && rd_en && wr_en && (data_size != 2'd0);
  assign accept        = start && xfer_end && (state == ST_IDLE) && !lane_conflict;
  assign ev_empty      = accept && (strm.len == '0);
  assign ev_last       = ev_fall && last_bit;
  assign in_fin        = (state == ST_FIN);
  assign running       = (state == ST_RUN);

  spi_xfer_clkgen #(.DIV_HALF(DIV_HALF)) clkgen_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .sclk    (sclk),
    .ev_rise (ev_rise),
    .ev_fall (ev_fall)
  );

  spi_xfer_shifter shifter_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .load_stream (strm),
    .dlen        (dlen_q),
    .capture_en  (rd_q),
    .ev_rise     (ev_rise),
    .ev_fall     (ev_fall),
    .miso        (miso),
    .mosi        (mosi),
    .rbuf        (rbuf),
    .last_bit    (last_bit),
    .in_data     (in_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cs_n      <= 1'b1;
      xfer_end  <= 1'b1;
      start_err <= 1'b0;
      keep_q    <= 1'b0;
      rd_q      <= 1'b0;
      dlen_q    <= '0;
      rdata     <= '0;
    end else begin
      start_err <= start && !accept;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cs_n     <= 1'b0;
            xfer_end <= 1'b0;
            keep_q   <= keep_cs;
            rd_q     <= rd_en && (data_size != 2'd0);
            dlen_q   <= data_len(data_size);
            state    <= ev_empty ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (ev_last) state <= ST_FIN;
        end
        ST_FIN: begin
          xfer_end <= 1'b1;
          cs_n     <= !keep_q;
          if (rd_q) rdata <= rbuf;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_xfer_checker.sv
module spi_xfer_checker (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic xfer_end,
  input logic start_err,
  input logic ev_rise,
  input logic ev_fall,
  input logic ev_last,
  input logic in_fin
);
  p_sclk_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> !sclk);

  p_mosi_hold_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  p_edges_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_rise, ev_fall}));

  p_select_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_end |-> !cs_n);

  p_last_then_fin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> in_fin);

  p_end_follows_fin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_end) |-> $past(in_fin));

  p_reject_keeps_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_err && $past(xfer_end)) |-> xfer_end);

  p_no_edge_unselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rise |-> !cs_n);
endmodule

bind spi_xfer_engine spi_xfer_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk      (sclk),
  .mosi      (mosi),
  .cs_n      (cs_n),
  .xfer_end  (xfer_end),
  .start_err (start_err),
  .ev_rise   (ev_rise),
  .ev_fall   (ev_fall),
  .ev_last   (ev_last),
  .in_fin    (in_fin)
);

// File: tb/spi_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module spi_xfer_engine_tb_top;
  localparam int DIVH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cmd_en = 1'b0, ocmd_en = 1'b0, addr_en = 1'b0, opt_en = 1'b0, dummy_en = 1'b0;
  logic [7:0]  cmd = '0, ocmd = '0;
  logic [23:0] addr = '0;
  logic [1:0]  opt_len = '0;
  logic [31:0] opt_data = '0;
  logic [2:0]  dummy_cyc = '0;
  logic [1:0]  data_size = '0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0, lane_wide = 1'b0, keep_cs = 1'b0;
  logic        miso = 1'b0;
  logic        sclk, cs_n, mosi, xfer_end, start_err;
  logic [31:0] rdata;

  int          n_tests = 0;
  int          n_fail = 0;
  int          rise_cnt = 0;
  bit          got_q[$];
  bit          exp_q[$];
  logic [127:0] mpat = '0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] last_rdata = '0;

  always #2 clk = ~clk;

  spi_xfer_engine #(.DIV_HALF(DIVH)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_en(cmd_en), .cmd(cmd), .ocmd_en(ocmd_en), .ocmd(ocmd),
    .addr_en(addr_en), .addr(addr), .opt_en(opt_en), .opt_len(opt_len),
    .opt_data(opt_data), .dummy_en(dummy_en), .dummy_cyc(dummy_cyc),
    .data_size(data_size), .wdata(wdata), .rd_en(rd_en), .wr_en(wr_en),
    .lane_wide(lane_wide), .keep_cs(keep_cs), .miso(miso),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .rdata(rdata),
    .xfer_end(xfer_end), .start_err(start_err)
  );

  // Flash model: record MOSI on each rising SCLK, then present the next MISO bit.
  always @(posedge sclk) begin
    if (!cs_n) begin
      got_q.push_back(mosi);
      rise_cnt = rise_cnt + 1;
    end
    #1;
    miso = mpat[rise_cnt];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {seed[15:0], seed[31:16]} ^ (seed >> 7);
  endfunction

  function automatic int dbits(input logic [1:0] c);
    return (c == 2'd0) ? 0 : (4 << c);
  endfunction

  task automatic push_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) exp_q.push_back(v[i]);
  endtask

  task automatic expect_stream();
    exp_q.delete();
    if (cmd_en)  push_bits({24'd0, cmd}, 8);
    if (ocmd_en) push_bits({24'd0, ocmd}, 8);
    if (addr_en) push_bits({8'd0, addr}, 24);
    if (opt_en)
      for (int b = 0; b <= int'(opt_len); b++)
        push_bits({24'd0, opt_data[31 - 8 * b -: 8]}, 8);
    if (dummy_en)
      for (int k = 0; k <= int'(dummy_cyc); k++) exp_q.push_back(1'b0);
    if (data_size != 2'd0) push_bits(wr_en ? wdata : 32'd0, dbits(data_size));
  endtask

  task automatic run_xfer(input string tag, input bit exp_keep, input int poke);
    int len, cyc, mism, dl;
    logic [31:0] rexp;
    expect_stream();
    len = exp_q.size();
    got_q.delete();
    rise_cnt = 0;
    miso = mpat[0];
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 1;
    check(xfer_end == 1'b0 && cs_n == 1'b0, "R7", "busy after start", {xfer_end, cs_n}, 0);
    while (!xfer_end && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (poke > 0 && cyc == poke) start = 1'b1;
      else start = 1'b0;
      if (poke > 0 && cyc == poke + 1)
        check(start_err == 1'b1, "R9", "busy start refused", start_err, 1);
    end
    start = 1'b0;
    mism = 0;
    for (int i = 0; i < len && i < got_q.size(); i++) if (got_q[i] != exp_q[i]) mism++;
    check(mism == 0 && got_q.size() == len, tag, "mosi stream len/mismatch",
          got_q.size() * 1000 + mism, len * 1000);
    check(cyc == 2 * DIVH * len + 2, "R6", "cycles to end", cyc, 2 * DIVH * len + 2);
    check(cs_n == !exp_keep && sclk == 1'b0, "R7", "select after end", cs_n, !exp_keep);
    dl = dbits(data_size);
    rexp = last_rdata;
    if (rd_en && dl > 0) begin
      rexp = '0;
      for (int k = len - dl; k < len; k++) rexp = {rexp[30:0], mpat[k]};
    end
    check(rdata == rexp, "R5", "read data", rdata, rexp);
    last_rdata = rexp;
  endtask

  task automatic clear_cfg();
    cmd_en = 0; ocmd_en = 0; addr_en = 0; opt_en = 0; dummy_en = 0;
    data_size = 0; rd_en = 0; wr_en = 0; lane_wide = 0; keep_cs = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(cs_n == 1 && sclk == 0 && mosi == 0 && xfer_end == 1 && start_err == 0 && rdata == 0,
          "R11", "reset outputs", {cs_n, sclk, mosi, xfer_end, start_err}, 5'b10010);

    // R1: every combination of phase enables
    for (int i = 0; i < 64; i++) begin
      mpat = {rnd(), rnd(), rnd(), rnd()};
      cmd = rnd(); ocmd = rnd(); addr = rnd(); opt_data = rnd(); wdata = rnd();
      cmd_en = i[0]; ocmd_en = i[1]; addr_en = i[2]; opt_en = i[3]; dummy_en = i[4];
      data_size = i[5] ? 2'(1 + (i % 3)) : 2'd0;
      opt_len = 2'((i / 2) % 4);
      dummy_cyc = 3'((i * 3) % 8);
      {rd_en, wr_en} = 2'(rnd());
      keep_cs = 0; lane_wide = 0;
      run_xfer("R1", 1'b0, 0);
    end

    // R3: dummy count sweep, MOSI low
    clear_cfg();
    for (int d = 0; d < 8; d++) begin
      cmd_en = 1; cmd = 8'hA5; dummy_en = 1; dummy_cyc = 3'(d);
      run_xfer("R3", 1'b0, 0);
    end

    // R2: option byte count sweep
    clear_cfg();
    for (int o = 0; o < 4; o++) begin
      opt_en = 1; opt_len = 2'(o); opt_data = 32'hC3_5A_0F_96;
      run_xfer("R2", 1'b0, 0);
    end

    // R4 and R5: each data size, full duplex, then write only
    clear_cfg();
    for (int s = 1; s < 4; s++) begin
      mpat = {rnd(), rnd(), rnd(), rnd()};
      data_size = 2'(s); wdata = 32'h8E1D_B2F7; rd_en = 1; wr_en = 1;
      run_xfer("R4", 1'b0, 0);
      rd_en = 0;
      run_xfer("R4", 1'b0, 0);
      wr_en = 0; rd_en = 1;
      run_xfer("R4", 1'b0, 0);
    end

    // R12: nothing enabled
    clear_cfg();
    run_xfer("R12", 1'b0, 0);
    check(rise_cnt == 0, "R12", "no sclk edges", rise_cnt, 0);

    // R8: keep select, then continue with payload and release
    clear_cfg();
    cmd_en = 1; cmd = 8'h02; addr_en = 1; addr = 24'h012345; keep_cs = 1;
    run_xfer("R8", 1'b1, 0);
    repeat (10) @(negedge clk);
    check(cs_n == 1'b0, "R8", "select held while idle", cs_n, 0);
    clear_cfg();
    data_size = 2'd3; wr_en = 1; wdata = 32'hDEAD_BEEF;
    run_xfer("R8", 1'b0, 0);

    // R9: start requested mid-transfer
    clear_cfg();
    cmd_en = 1; cmd = 8'h3C; addr_en = 1; addr = 24'hABCDEF;
    run_xfer("R9", 1'b0, 20);

    // R10: wide lanes with both directions refused
    clear_cfg();
    lane_wide = 1; rd_en = 1; wr_en = 1; data_size = 2'd1; cmd_en = 1;
    rise_cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(start_err == 1'b1, "R10", "wide rd+wr refused", start_err, 1);
    repeat (20) @(negedge clk);
    check(cs_n == 1 && xfer_end == 1 && rise_cnt == 0, "R10", "no transfer after refusal",
          {cs_n, xfer_end, 8'(rise_cnt)}, 10'h300);
    wr_en = 0;
    mpat = {rnd(), rnd(), rnd(), rnd()};
    run_xfer("R10", 1'b0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule